// File: doc/BRIEF.md
# Differential PSK/QAM Symbol Mapper

This block turns a serial bit stream into constellation points for a transmit chain. Bits arrive one at a time with a qualifier and are gathered into a small buffer. Each time the symbol-rate strobe is high and the buffer holds a full symbol, the block emits one pair of 8-bit signed I and Q samples together with a one-cycle valid pulse. The first bit gathered into a symbol is that symbol's most significant bit.

A 6-bit code selects the constellation: binary PSK, quaternary PSK, pi/4-shifted differential QPSK or 16-point QAM. A separate control switches binary and quaternary PSK from absolute to differential mapping. In the differential modes, a 3-bit phase accumulator in 45-degree steps is advanced by the symbol bits, and the output point sits at the new phase. Phase p stands for angle 45*p degrees, counter-clockwise from the +I axis. Axis points use amplitude 127 and diagonal points use 90 on each axis. A spectrum-inversion control negates Q on every mode.

Top module: `psk_symbol_mapper`

## Requirements
- R1: Codes 0 (BPSK), 1 (QPSK), 12 (pi/4 DQPSK) and 16 (16QAM) are served, using 1, 2, 2 and 4 bits per symbol. Every other code is reserved: it gathers no bits and never raises sym_vld.
- R2: Absolute BPSK (code 0, diff_en=0) maps bit 0 to (127,0) and bit 1 to (-127,0).
- R3: Absolute QPSK (code 1, diff_en=0) maps symbol 00 to (90,90), 01 to (-90,90), 11 to (-90,-90) and 10 to (90,-90). The symbol is written first bit first.
- R4: Differential BPSK (code 0, diff_en=1) adds 0 degrees for bit 0 and 180 degrees for bit 1 to the phase, then outputs the point at the new phase.
- R5: Differential QPSK (code 1, diff_en=1) adds 0, 90, 180 or 270 degrees for symbols 00, 01, 10 or 11, then outputs the point at the new phase.
- R6: pi/4 DQPSK (code 12, whatever diff_en is) adds the QPSK increment plus 45 degrees. The eight phases map to (127,0), (90,90), (0,127), (-90,90), (-127,0), (-90,-90), (0,-127) and (90,-90) for p = 0 to 7.
- R7: In 16QAM the first two bits select I and the last two select Q. Each pair is Gray coded: 00 gives -127, 01 gives -42, 11 gives +42 and 10 gives +127.
- R8: With inv_q=1 the Q output is the negation of the normal Q value. I is unchanged.
- R9: A symbol is produced only on a clock edge where sym_strobe is high and a full symbol is buffered. sym_vld rises in the cycle after that edge for exactly one cycle, and sym_i and sym_q hold their last values in between.
- R10: A bit that arrives while a full symbol waits is discarded. A bit that arrives in the same cycle as a consuming strobe becomes the first bit of the next symbol.
- R11: Reset, and any change of mod_sel or diff_en, returns the phase to 0 and drops the buffered bits. The bit, and any strobe, in the cycle of the change are ignored.
- R12: After reset sym_vld, sym_i and sym_q are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_sel | input | 6 | Modulation code |
| diff_en | input | 1 | Differential mapping for BPSK/QPSK |
| inv_q | input | 1 | Negate Q output |
| bit_vld | input | 1 | bit_in carries a bit this cycle |
| bit_in | input | 1 | Serial data bit |
| sym_strobe | input | 1 | Symbol-rate request |
| sym_vld | output | 1 | New symbol on sym_i/sym_q |
| sym_i | output | 8 | In-phase sample, signed |
| sym_q | output | 8 | Quadrature sample, signed |

## Verification
The hardest state to reach from the ports is a phase accumulator that has moved away from zero, followed by a mode change. Only then does the phase reset show at the outputs. The bench walks differential QPSK through two increments and leaves a lone bit in the buffer. It then toggles diff_en off and back on, and checks that the next symbol lands on the first-step point again, with the stray bit gone. The rules on full buffers and on a bit arriving with the strobe are reached with hand-timed bit and strobe sequences in absolute QPSK and BPSK.

// File: rtl/dpsk_map_pkg.sv
// Shared types and code values for the symbol mapper.
// Assumes modulation codes are 6 bits wide.
package dpsk_map_pkg;
    typedef enum logic [2:0] {
        MK_NONE  = 3'd0,
        MK_BPSK  = 3'd1,
        MK_QPSK  = 3'd2,
        MK_PI4   = 3'd3,
        MK_QAM16 = 3'd4
    } map_kind_e;

    localparam logic [5:0] CODE_BPSK  = 6'd0;
    localparam logic [5:0] CODE_QPSK  = 6'd1;
    localparam logic [5:0] CODE_PI4   = 6'd12;
    localparam logic [5:0] CODE_QAM16 = 6'd16;

    localparam int MAX_BITS = 4;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);
    localparam int PH_W     = 3;
endpackage

// File: rtl/map_mode_decode.sv
// Decodes the modulation code into a mapping kind and bits per symbol.
// Assumes reserved codes yield MK_NONE and zero bits per symbol.
module map_mode_decode
    import dpsk_map_pkg::*;
(
    input  logic [5:0]       mod_sel,
    output map_kind_e        kind,
    output logic [CNT_W-1:0] need
);
    // Pick the kind and symbol width for the code.
    always_comb begin
        kind = MK_NONE;
        need = '0;
        case (mod_sel)
            CODE_BPSK:  begin kind = MK_BPSK;  need = CNT_W'(1); end
            CODE_QPSK:  begin kind = MK_QPSK;  need = CNT_W'(2); end
            CODE_PI4:   begin kind = MK_PI4;   need = CNT_W'(2); end
            CODE_QAM16: begin kind = MK_QAM16; need = CNT_W'(4); end
            default:    begin kind = MK_NONE;  need = '0;        end
        endcase
    end
endmodule

// File: rtl/map_bit_gather.sv
// Collects serial bits into a symbol, first bit in the highest used position.
// Assumes need never exceeds MAXB; a zero need gathers nothing.
module map_bit_gather #(
    parameter int MAXB = 4,
    parameter int CW   = $clog2(MAXB + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            bit_vld,
    input  logic            bit_in,
    input  logic [CW-1:0]   need,
    input  logic            take,
    output logic [MAXB-1:0] bits,
    output logic [CW-1:0]   cnt,
    output logic            full
);
    // A symbol is ready once the count reaches a non-zero need.
    assign full = (need != '0) && (cnt == need);

    // Shift in bits, drop extras, restart on consumption or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            bits <= '0;
            cnt  <= '0;
        end else if (take) begin
            bits <= {{(MAXB-1){1'b0}}, bit_in & bit_vld};
            cnt  <= bit_vld ? CW'(1) : '0;
        end else if (bit_vld && (cnt < need)) begin
            bits <= {bits[MAXB-2:0], bit_in};
            cnt  <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/map_phase_accum.sv
// Produces the output phase index for the PSK modes and keeps the
// differential phase state. Assumes sym holds the symbol's low bits.
module map_phase_accum
    import dpsk_map_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            adv,
    input  map_kind_e       kind,
    input  logic            diff_en,
    input  logic [1:0]      sym,
    output logic [PH_W-1:0] phase
);
    logic [PH_W-1:0] acc;
    logic [PH_W-1:0] inc;
    logic [PH_W-1:0] abs_ph;
    logic            is_diff;

    // Work out the increment and the absolute phase for the symbol.
    always_comb begin
        inc    = '0;
        abs_ph = '0;
        case (kind)
            MK_BPSK: begin
                inc    = sym[0] ? PH_W'(4) : '0;
                abs_ph = inc;
            end
            MK_QPSK: begin
                inc = {sym, 1'b0};
                case (sym)
                    2'b00:   abs_ph = PH_W'(1);
                    2'b01:   abs_ph = PH_W'(3);
                    2'b11:   abs_ph = PH_W'(5);
                    default: abs_ph = PH_W'(7);
                endcase
            end
            MK_PI4:  inc = {sym, 1'b0} + PH_W'(1);
            default: inc = '0;
        endcase
    end

    // Differential modes step from the stored phase.
    assign is_diff = (kind == MK_PI4) ||
                     (diff_en && ((kind == MK_BPSK) || (kind == MK_QPSK)));
    assign phase   = is_diff ? (acc + inc) : abs_ph;

    // Store the new phase when a differential symbol is emitted.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            acc <= '0;
        else if (adv && is_diff)
            acc <= phase;
    end
endmodule

// File: rtl/map_point_lut.sv
// Turns a phase index or 16QAM bits into signed I/Q, with optional Q negation.
// Assumes UNIT, DIAG and INNER all fit in W signed bits.
module map_point_lut
    import dpsk_map_pkg::*;
#(
    parameter int W     = 8,
    parameter int UNIT  = 127,
    parameter int DIAG  = 90,
    parameter int INNER = 42
) (
    input  map_kind_e              kind,
    input  logic [PH_W-1:0]        phase,
    input  logic [3:0]             qbits,
    input  logic                   inv,
    output logic signed [W-1:0]    pt_i,
    output logic signed [W-1:0]    pt_q
);
    localparam logic signed [W-1:0] PU = W'(UNIT);
    localparam logic signed [W-1:0] PD = W'(DIAG);
    localparam logic signed [W-1:0] PN = W'(INNER);

    logic signed [W-1:0] raw_q;

    // Gray level for one 16QAM axis.
    function automatic logic signed [W-1:0] qam_lvl(input logic [1:0] b);
        case (b)
            2'b00:   return -PU;
            2'b01:   return -PN;
            2'b11:   return PN;
            default: return PU;
        endcase
    endfunction

    // Select the point for the current kind.
    always_comb begin
        if (kind == MK_QAM16) begin
            pt_i  = qam_lvl(qbits[3:2]);
            raw_q = qam_lvl(qbits[1:0]);
        end else begin
            case (phase)
                3'd0:    begin pt_i = PU;  raw_q = '0;  end
                3'd1:    begin pt_i = PD;  raw_q = PD;  end
                3'd2:    begin pt_i = '0;  raw_q = PU;  end
                3'd3:    begin pt_i = -PD; raw_q = PD;  end
                3'd4:    begin pt_i = -PU; raw_q = '0;  end
                3'd5:    begin pt_i = -PD; raw_q = -PD; end
                3'd6:    begin pt_i = '0;  raw_q = -PU; end
                default: begin pt_i = PD;  raw_q = -PD; end
            endcase
        end
    end

    // Apply spectrum inversion to Q.
    assign pt_q = inv ? -raw_q : raw_q;
endmodule

// File: rtl/psk_symbol_mapper.sv
// Top of the symbol mapper: gathers bits, steps phase, looks up points.
// Assumes one bit at most per clock and a strobe no faster than the data.
module psk_symbol_mapper
    import dpsk_map_pkg::*;
#(
    parameter int AMP_W      = 8,
    parameter int UNIT_AMP   = 127,
    parameter int DIAG_AMP   = 90,
    parameter int QAM_INNER  = 42
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [5:0]              mod_sel,
    input  logic                    diff_en,
    input  logic                    inv_q,
    input  logic                    bit_vld,
    input  logic                    bit_in,
    input  logic                    sym_strobe,
    output logic                    sym_vld,
    output logic signed [AMP_W-1:0] sym_i,
    output logic signed [AMP_W-1:0] sym_q
);
    map_kind_e           kind;
    logic [CNT_W-1:0]    need;
    logic [CNT_W-1:0]    cnt;
    logic [MAX_BITS-1:0] bits;
    logic                full;
    logic                take;
    logic                clr;
    logic [6:0]          key_q;
    logic [PH_W-1:0]     phase;
    logic signed [AMP_W-1:0] pt_i;
    logic signed [AMP_W-1:0] pt_q;

    // Remember the mode so a change can be seen.
    always_ff @(posedge clk) begin
        key_q <= {diff_en, mod_sel};
    end

    assign clr  = ({diff_en, mod_sel} != key_q);
    assign take = sym_strobe && full && !clr;

    map_mode_decode u_dec (
        .mod_sel (mod_sel),
        .kind    (kind),
        .need    (need)
    );

    map_bit_gather #(.MAXB(MAX_BITS), .CW(CNT_W)) u_gather (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .need    (need),
        .take    (take),
        .bits    (bits),
        .cnt     (cnt),
        .full    (full)
    );

    map_phase_accum u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .adv     (take),
        .kind    (kind),
        .diff_en (diff_en),
        .sym     (bits[1:0]),
        .phase   (phase)
    );

    map_point_lut #(.W(AMP_W), .UNIT(UNIT_AMP), .DIAG(DIAG_AMP), .INNER(QAM_INNER)) u_lut (
        .kind  (kind),
        .phase (phase),
        .qbits (bits),
        .inv   (inv_q),
        .pt_i  (pt_i),
        .pt_q  (pt_q)
    );

    // Register the point and pulse valid for each emitted symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_vld <= 1'b0;
            sym_i   <= '0;
            sym_q   <= '0;
        end else begin
            sym_vld <= take;
            if (take) begin
                sym_i <= pt_i;
                sym_q <= pt_q;
            end
        end
    end
endmodule

// File: rtl/psk_symbol_mapper_chk.sv
// Checker for the symbol mapper; bound to every instance of the top.
// Assumes the bound instance exposes cnt and need.
module psk_symbol_mapper_chk #(
    parameter int AMP_W     = 8,
    parameter int UNIT_AMP  = 127,
    parameter int QAM_INNER = 42,
    parameter int CW        = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [5:0]              mod_sel,
    input logic                    diff_en,
    input logic                    sym_strobe,
    input logic                    sym_vld,
    input logic signed [AMP_W-1:0] sym_i,
    input logic signed [AMP_W-1:0] sym_q,
    input logic [CW-1:0]           cnt,
    input logic [CW-1:0]           need
);
    localparam logic signed [AMP_W-1:0] U = AMP_W'(UNIT_AMP);
    localparam logic signed [AMP_W-1:0] N = AMP_W'(QAM_INNER);

    AST_VLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld |-> $past(sym_strobe)); // R9

    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld |-> ($past(mod_sel) == 6'd0 || $past(mod_sel) == 6'd1 ||
                     $past(mod_sel) == 6'd12 || $past(mod_sel) == 6'd16)); // R1

    AST_CHANGE_NO_SYM: assert property (@(posedge clk) disable iff (!rst_n)
        ({diff_en, mod_sel} != $past({diff_en, mod_sel})) |=> !sym_vld); // R11

    AST_BPSK_ON_AXIS: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_vld && $past(mod_sel, 2) == 6'd0 && $past(mod_sel) == 6'd0)
        |-> (sym_q == '0 && (sym_i == U || sym_i == -U))); // R2

    AST_QAM_GRID: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_vld && $past(mod_sel) == 6'd16)
        |-> ((sym_i == U || sym_i == -U || sym_i == N || sym_i == -N) &&
             (sym_q == U || sym_q == -U || sym_q == N || sym_q == -N))); // R7

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ({diff_en, mod_sel} == $past({diff_en, mod_sel})) |-> (cnt <= need)); // R10
endmodule

bind psk_symbol_mapper psk_symbol_mapper_chk #(
    .AMP_W(AMP_W), .UNIT_AMP(UNIT_AMP), .QAM_INNER(QAM_INNER), .CW(dpsk_map_pkg::CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mod_sel    (mod_sel),
    .diff_en    (diff_en),
    .sym_strobe (sym_strobe),
    .sym_vld    (sym_vld),
    .sym_i      (sym_i),
    .sym_q      (sym_q),
    .cnt        (cnt),
    .need       (need)
);

// File: tb/sim_psk_symbol_mapper.sv
// Directed bench for the symbol mapper; inputs change and outputs are read on falling edges.
module sim_psk_symbol_mapper;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [5:0]        mod_sel = 6'd0;
    logic              diff_en = 1'b0;
    logic              inv_q = 1'b0;
    logic              bit_vld = 1'b0;
    logic              bit_in = 1'b0;
    logic              sym_strobe = 1'b0;
    logic              sym_vld;
    logic signed [7:0] sym_i;
    logic signed [7:0] sym_q;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    psk_symbol_mapper u0 (
        .clk(clk), .rst_n(rst_n), .mod_sel(mod_sel), .diff_en(diff_en),
        .inv_q(inv_q), .bit_vld(bit_vld), .bit_in(bit_in),
        .sym_strobe(sym_strobe), .sym_vld(sym_vld), .sym_i(sym_i), .sym_q(sym_q)
    );

    // Compare outputs against expected values at the current sample point.
    task automatic expect_out(input string req, input logic ev, input int ei, input int eq);
        checks++;
        if (sym_vld !== ev || (ev && (int'(sym_i) != ei || int'(sym_q) != eq))) begin
            fails++;
            $display("FAIL %s: got vld=%0b i=%0d q=%0d, expected vld=%0b i=%0d q=%0d",
                     req, sym_vld, sym_i, sym_q, ev, ei, eq);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); bit_vld = 1'b1; bit_in = b;
        @(negedge clk); bit_vld = 1'b0;
    endtask

    // Strobe once; the output registered at that edge is visible at the next falling edge.
    task automatic strobe_check(input string req, input logic ev, input int ei, input int eq);
        @(negedge clk); sym_strobe = 1'b1;
        @(negedge clk); sym_strobe = 1'b0;
        expect_out(req, ev, ei, eq);
    endtask

    task automatic set_mode(input logic [5:0] m, input logic d);
        @(negedge clk); mod_sel = m; diff_en = d;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        expect_out("R12", 1'b0, 0, 0);
        checks++;
        if (sym_i !== 8'sd0 || sym_q !== 8'sd0) begin
            fails++;
            $display("FAIL R12: got i=%0d q=%0d, expected 0 0", sym_i, sym_q);
        end
    endtask

    task automatic t_bpsk_abs;
        set_mode(6'd0, 1'b0);
        send_bit(1'b0); strobe_check("R2", 1'b1, 127, 0);
        send_bit(1'b1); strobe_check("R2", 1'b1, -127, 0);
        @(negedge clk);
        expect_out("R9 hold", 1'b0, 0, 0);
        checks++;
        if (int'(sym_i) != -127) begin
            fails++;
            $display("FAIL R9: got i=%0d held, expected -127", sym_i);
        end
    endtask

    task automatic t_qpsk_abs;
        set_mode(6'd1, 1'b0);
        send_bit(0); send_bit(0); strobe_check("R3", 1'b1, 90, 90);
        send_bit(0); send_bit(1); strobe_check("R3", 1'b1, -90, 90);
        send_bit(1); send_bit(1); strobe_check("R3", 1'b1, -90, -90);
        send_bit(1); send_bit(0); strobe_check("R3", 1'b1, 90, -90);
    endtask

    task automatic t_bpsk_diff;
        set_mode(6'd0, 1'b1);
        send_bit(1); strobe_check("R4", 1'b1, -127, 0);
        send_bit(1); strobe_check("R4", 1'b1, 127, 0);
        send_bit(0); strobe_check("R4", 1'b1, 127, 0);
    endtask

    task automatic t_qpsk_diff_and_change;
        set_mode(6'd1, 1'b1);
        send_bit(0); send_bit(1); strobe_check("R5", 1'b1, 0, 127);
        send_bit(0); send_bit(1); strobe_check("R5", 1'b1, -127, 0);
        send_bit(1); send_bit(0); strobe_check("R5", 1'b1, 127, 0);
        send_bit(1); send_bit(1); strobe_check("R5", 1'b1, 0, -127);
        send_bit(1);
        set_mode(6'd1, 1'b0);
        set_mode(6'd1, 1'b1);
        send_bit(0); send_bit(1); strobe_check("R11", 1'b1, 0, 127);
    endtask

    task automatic t_pi4;
        set_mode(6'd12, 1'b0);
        send_bit(0); send_bit(0); strobe_check("R6", 1'b1, 90, 90);
        send_bit(0); send_bit(0); strobe_check("R6", 1'b1, 0, 127);
        send_bit(1); send_bit(1); strobe_check("R6", 1'b1, 90, 90);
    endtask

    task automatic t_qam;
        set_mode(6'd16, 1'b0);
        send_bit(1); send_bit(0); send_bit(1); send_bit(1);
        strobe_check("R7", 1'b1, 127, 42);
        send_bit(0); send_bit(0); send_bit(0); send_bit(1);
        strobe_check("R7", 1'b1, -127, -42);
    endtask

    task automatic t_invert;
        set_mode(6'd1, 1'b0);
        @(negedge clk); inv_q = 1'b1;
        send_bit(0); send_bit(0); strobe_check("R8", 1'b1, 90, -90);
        set_mode(6'd16, 1'b0);
        send_bit(0); send_bit(1); send_bit(1); send_bit(0);
        strobe_check("R8", 1'b1, -42, -127);
        @(negedge clk); inv_q = 1'b0;
    endtask

    task automatic t_flow;
        set_mode(6'd1, 1'b0);
        send_bit(0); send_bit(0); send_bit(1);
        strobe_check("R10", 1'b1, 90, 90);
        send_bit(1); strobe_check("R9 short", 1'b0, 0, 0);
        send_bit(0); strobe_check("R10", 1'b1, 90, -90);
        set_mode(6'd0, 1'b0);
        send_bit(1);
        @(negedge clk); sym_strobe = 1'b1; bit_vld = 1'b1; bit_in = 1'b0;
        @(negedge clk); sym_strobe = 1'b0; bit_vld = 1'b0;
        expect_out("R10", 1'b1, -127, 0);
        strobe_check("R10", 1'b1, 127, 0);
    endtask

    task automatic t_reserved;
        set_mode(6'd5, 1'b0);
        send_bit(1); send_bit(0); send_bit(1); send_bit(1);
        strobe_check("R1", 1'b0, 0, 0);
        set_mode(6'd2, 1'b0);
        send_bit(1); send_bit(1);
        strobe_check("R1", 1'b0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_bpsk_abs();
        t_qpsk_abs();
        t_bpsk_diff();
        t_qpsk_diff_and_change();
        t_pi4();
        t_qam();
        t_invert();
        t_flow();
        t_reserved();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule